// File: doc/BRIEF.md
# Maskable Two-Channel Calendar Alarm Comparator

This block watches a running BCD calendar (seconds, minutes, hours, day of month and weekday) and compares it against programmed alarm settings held in two independent channels. When every field a channel cares about equals the calendar at a one-second tick, that channel raises a sticky flag that stays set until it is cleared. An interrupt line combines both channels' flags with their interrupt enables.

Each channel carries a mask bit per field. A masked field is left out of the comparison, which turns a one-shot alarm into a periodic one: masking everything but the seconds gives one alarm per minute, and masking everything gives one per second. A select bit tells the channel whether its day field holds a day of month or a weekday. Alarm settings may only be rewritten while the channel is disabled and its write-allowed status has come up. The status comes up a fixed number of cycles after the enable drops, which models the time the alarm logic needs to let go of the old settings.

Top module: `cal_alarm_cmp`

## Requirements
- R1: In the cycle after a reset, `wr_ok`, `flag_o` and `irq_o` are all zero. Every channel's stored setting is all zero, so masks are clear, the select is day-of-month and the stored values are 0.
- R2: The setting word `wr_data` has this layout: sec [6:0], min [13:7], hour [19:14], day [25:20], weekday select [26], and the masks for sec [27], min [28], hour [29] and day [30]. All values are BCD, with hours in 24-hour form. An enabled channel whose unmasked fields all equal the calendar when `sec_tick` is sampled high has its flag set at that same clock edge.
- R3: A set mask bit removes its field from the comparison. With all four mask bits set, the flag sets on every `sec_tick` while the channel is enabled.
- R4: With the select bit at 0, the day field is compared with `cal_mday`. With the select bit at 1, it is compared with `cal_wday` zero-extended to 6 bits, where weekdays run from 1 (Monday) to 7 (Sunday).
- R5: The flag never rises at an edge where `sec_tick` is low, and never rises for a channel whose `alm_en` is low, however well the calendar matches.
- R6: Once set, a flag holds until its `flag_clr` bit is sampled high. If a new match and a clear arrive in the same cycle, the flag stays set.
- R7: `wr_ok` falls at the first edge where `alm_en` is sampled high. It rises at the WR_LAT-th consecutive edge with `alm_en` sampled low. WR_LAT defaults to 3.
- R8: A `wr_stb` pulse stores `wr_data` only if that channel's `wr_ok` is high in the same cycle. Otherwise the write is ignored and the old setting stays in force.
- R9: Channels are independent. A write, enable, match or clear on one channel never changes the other channel's flag, `wr_ok` or setting.
- R10: `irq_o` updates at the same edge as the flags. It equals the OR over channels of the new flag AND that channel's `irq_en` sampled at that edge.

Ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per calendar second |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD, 24-hour |
| cal_mday | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday, 1..7, Sunday = 7 |
| alm_en | input | NUM_CH | Per-channel alarm enable |
| irq_en | input | NUM_CH | Per-channel interrupt enable |
| wr_stb | input | NUM_CH | Per-channel setting write strobe |
| wr_data | input | 31 | Alarm setting word (layout in R2) |
| flag_clr | input | NUM_CH | Per-channel flag clear pulse |
| wr_ok | output | NUM_CH | Per-channel write-allowed status |
| flag_o | output | NUM_CH | Per-channel sticky alarm flag |
| irq_o | output | 1 | Combined alarm interrupt |

## Verification
Two functions can meet in one cycle: a fresh match that sets a flag, and a software clear of that same flag. The bench provokes this by holding a matching calendar, then pulsing `sec_tick` and `flag_clr` together. Set must win, so the flag is expected to stay high. A second collision is a write strobe in the very cycle the enable rises; the write still lands, because `wr_ok` only drops at that edge. A behavioural model in the bench is compared with every output on every clock.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int CFG_W = 31;

  // Alarm setting word; the first member sits at the top bit.
  typedef struct packed {
    logic       msk_day;   // [30]
    logic       msk_hour;  // [29]
    logic       msk_min;   // [28]
    logic       msk_sec;   // [27]
    logic       wday_sel;  // [26] 1: day field is a weekday
    logic [5:0] day;       // [25:20]
    logic [5:0] hour;      // [19:14]
    logic [6:0] min;       // [13:7]
    logic [6:0] sec;       // [6:0]
  } alarm_cfg_t;

  typedef struct packed {
    logic [2:0] wday;
    logic [5:0] mday;
    logic [5:0] hour;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_now_t;

endpackage

// File: rtl/alarm_match.sv
module alarm_match
  import cal_alarm_pkg::*;
(
  input  alarm_cfg_t cfg,
  input  cal_now_t   now,
  output logic       hit
);
  logic sec_ok, min_ok, hour_ok, day_ok;
  logic day_eq;

  always_comb begin
    if (cfg.wday_sel) day_eq = (cfg.day == {3'b000, now.wday});
    else              day_eq = (cfg.day == now.mday);
    sec_ok  = cfg.msk_sec  | (cfg.sec  == now.sec);
    min_ok  = cfg.msk_min  | (cfg.min  == now.min);
    hour_ok = cfg.msk_hour | (cfg.hour == now.hour);
    day_ok  = cfg.msk_day  | day_eq;
    hit     = sec_ok & min_ok & hour_ok & day_ok;
  end
endmodule

// File: rtl/alarm_wr_guard.sv
module alarm_wr_guard #(
  parameter int WR_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic ok
);
  localparam int CW = (WR_LAT < 2) ? 1 : $clog2(WR_LAT);
  localparam logic [CW-1:0] LAST = CW'(WR_LAT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (en) begin
      cnt <= '0;
      ok  <= 1'b0;
    end else if (!ok) begin
      if (cnt == LAST) ok <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
  import cal_alarm_pkg::*;
#(
  parameter int WR_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  cal_now_t         now,
  input  logic             wr_stb,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             clr,
  output logic             wr_ok,
  output logic             flag,
  output logic             flag_nxt
);
  alarm_cfg_t cfg_q;
  logic       hit;

  alarm_wr_guard #(.WR_LAT(WR_LAT)) u_guard (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .ok  (wr_ok)
  );

  alarm_match u_match (
    .cfg (cfg_q),
    .now (now),
    .hit (hit)
  );

  always_ff @(posedge clk) begin
    if (rst)                  cfg_q <= '0;
    else if (wr_stb && wr_ok) cfg_q <= alarm_cfg_t'(wr_data);
  end

  // A new match outranks a clear arriving in the same cycle.
  always_comb flag_nxt = (tick & en & hit) | (flag & ~clr);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_nxt;
  end
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [6:0]        cal_sec,
  input  logic [6:0]        cal_min,
  input  logic [5:0]        cal_hour,
  input  logic [5:0]        cal_mday,
  input  logic [2:0]        cal_wday,
  input  logic [NUM_CH-1:0] alm_en,
  input  logic [NUM_CH-1:0] irq_en,
  input  logic [NUM_CH-1:0] wr_stb,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [NUM_CH-1:0] flag_clr,
  output logic [NUM_CH-1:0] wr_ok,
  output logic [NUM_CH-1:0] flag_o,
  output logic              irq_o
);
  cal_now_t          now;
  logic [NUM_CH-1:0] flag_nxt;

  always_comb begin
    now.sec  = cal_sec;
    now.min  = cal_min;
    now.hour = cal_hour;
    now.mday = cal_mday;
    now.wday = cal_wday;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    alarm_channel #(.WR_LAT(WR_LAT)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .en       (alm_en[g]),
      .tick     (sec_tick),
      .now      (now),
      .wr_stb   (wr_stb[g]),
      .wr_data  (wr_data),
      .clr      (flag_clr[g]),
      .wr_ok    (wr_ok[g]),
      .flag     (flag_o[g]),
      .flag_nxt (flag_nxt[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(flag_nxt & irq_en);
  end
endmodule

// File: rtl/cal_alarm_cmp_chk.sv
module cal_alarm_cmp_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic [NUM_CH-1:0] alm_en,
  input logic [NUM_CH-1:0] irq_en,
  input logic [NUM_CH-1:0] flag_clr,
  input logic [NUM_CH-1:0] wr_ok,
  input logic [NUM_CH-1:0] flag_o,
  input logic              irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      (flag_o[g] && !flag_clr[g]) |=> flag_o[g]);

    assert_no_rise_without_tick_R5: assert property (@(posedge clk) disable iff (rst)
      !sec_tick |=> !$rose(flag_o[g]));

    assert_no_rise_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
      (!alm_en[g] && !flag_o[g]) |=> !flag_o[g]);

    assert_wr_ok_drops_R7: assert property (@(posedge clk) disable iff (rst)
      alm_en[g] |=> !wr_ok[g]);
  end

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == |(flag_o & $past(irq_en))));
endmodule

bind cal_alarm_cmp cal_alarm_cmp_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sec_tick (sec_tick),
  .alm_en   (alm_en),
  .irq_en   (irq_en),
  .flag_clr (flag_clr),
  .wr_ok    (wr_ok),
  .flag_o   (flag_o),
  .irq_o    (irq_o)
);

// File: tb/tb_cal_alarm_cmp.sv
module tb_cal_alarm_cmp;
  localparam int NCH = 2;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic [6:0] cal_sec = '0, cal_min = '0;
  logic [5:0] cal_hour = '0, cal_mday = '0;
  logic [2:0] cal_wday = '0;
  logic [NCH-1:0] alm_en = '0, irq_en = '0, wr_stb = '0, flag_clr = '0;
  logic [30:0] wr_data = '0;
  logic [NCH-1:0] wr_ok, flag_o;
  logic irq_o;

  cal_alarm_cmp #(.NUM_CH(NCH), .WR_LAT(LAT)) dut (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cal_sec(cal_sec), .cal_min(cal_min), .cal_hour(cal_hour),
    .cal_mday(cal_mday), .cal_wday(cal_wday),
    .alm_en(alm_en), .irq_en(irq_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .flag_clr(flag_clr), .wr_ok(wr_ok), .flag_o(flag_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // Reference model state
  logic [30:0] m_cfg [NCH];
  int          m_cnt [NCH];
  bit          m_ok  [NCH];
  bit          m_flag[NCH];
  bit          m_irq;

  int    n_total = 0;
  int    n_bad   = 0;
  string cur_req = "R1";

  function automatic bit model_hit(logic [30:0] c);
    bit s, m, h, d;
    int dayv;
    s = c[27] || (c[6:0]   == cal_sec);
    m = c[28] || (c[13:7]  == cal_min);
    h = c[29] || (c[19:14] == cal_hour);
    dayv = c[26] ? int'(cal_wday) : int'(cal_mday);
    d = c[30] || (int'(c[25:20]) == dayv);
    return s && m && h && d;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < NCH; c++) begin
      check(cur_req, $sformatf("wr_ok[%0d]", c), int'(wr_ok[c]), int'(m_ok[c]));
      check(cur_req, $sformatf("flag[%0d]", c), int'(flag_o[c]), int'(m_flag[c]));
    end
    check(cur_req, "irq", int'(irq_o), int'(m_irq));
  endtask

  // One clock: model next state from current inputs, edge, compare, drop pulses.
  task automatic tick();
    logic [30:0] n_cfg [NCH];
    int n_cnt [NCH];
    bit n_ok [NCH];
    bit n_flag [NCH];
    bit n_irq;
    n_irq = 0;
    for (int c = 0; c < NCH; c++) begin
      if (rst) begin
        n_cfg[c] = '0; n_cnt[c] = 0; n_ok[c] = 0; n_flag[c] = 0;
      end else begin
        n_cfg[c]  = (wr_stb[c] && m_ok[c]) ? wr_data : m_cfg[c];
        n_flag[c] = (sec_tick && alm_en[c] && model_hit(m_cfg[c])) ||
                    (m_flag[c] && !flag_clr[c]);
        n_cnt[c] = m_cnt[c]; n_ok[c] = m_ok[c];
        if (alm_en[c]) begin
          n_cnt[c] = 0; n_ok[c] = 0;
        end else if (!m_ok[c]) begin
          if (m_cnt[c] == LAT - 1) n_ok[c] = 1;
          else n_cnt[c] = m_cnt[c] + 1;
        end
        if (n_flag[c] && irq_en[c]) n_irq = 1;
      end
    end
    @(posedge clk);
    #5;
    for (int c = 0; c < NCH; c++) begin
      m_cfg[c] = n_cfg[c]; m_cnt[c] = n_cnt[c]; m_ok[c] = n_ok[c]; m_flag[c] = n_flag[c];
    end
    m_irq = rst ? 1'b0 : n_irq;
    compare_all();
    sec_tick = 0; wr_stb = '0; flag_clr = '0;
  endtask

  task automatic set_cal(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input logic [5:0] md, input logic [2:0] wd);
    cal_sec = s; cal_min = m; cal_hour = h; cal_mday = md; cal_wday = wd;
  endtask

  function automatic logic [30:0] mk(input logic [3:0] msk, input logic sel,
      input logic [5:0] d, input logic [5:0] h, input logic [6:0] m, input logic [6:0] s);
    return {msk, sel, d, h, m, s};
  endfunction

  task automatic program_ch(input int c, input logic [30:0] cfg);
    alm_en[c] = 0;
    for (int i = 0; i < 10 && !wr_ok[c]; i++) tick();
    check("R7", $sformatf("wr_ok[%0d] before write", c), int'(wr_ok[c]), 1);
    wr_stb[c] = 1; wr_data = cfg;
    tick();
  endtask

  task automatic clear_ch(input int c);
    flag_clr[c] = 1; tick();
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_cfg[c] = '0; m_cnt[c] = 0; m_ok[c] = 0; m_flag[c] = 0;
    end
    m_irq = 0;
    #5;
    // R1: reset state
    cur_req = "R1";
    repeat (3) tick();
    rst = 0;
    tick();
    check("R1", "flags after reset", int'(flag_o), 0);
    check("R1", "irq after reset", int'(irq_o), 0);
    // zero setting matches an all-zero calendar
    set_cal(0, 0, 0, 0, 0);
    alm_en[0] = 1; sec_tick = 1; tick();
    check("R1", "zero setting match", int'(flag_o[0]), 1);
    alm_en[0] = 0; clear_ch(0);

    // R2: exact match, near miss first
    cur_req = "R2";
    program_ch(0, mk(4'b0000, 0, 6'h25, 6'h12, 7'h15, 7'h30));
    alm_en[0] = 1;
    set_cal(7'h31, 7'h15, 6'h12, 6'h25, 3);
    sec_tick = 1; tick();
    check("R2", "near miss", int'(flag_o[0]), 0);
    set_cal(7'h30, 7'h15, 6'h12, 6'h25, 3);
    sec_tick = 1; tick();
    check("R2", "exact match", int'(flag_o[0]), 1);
    clear_ch(0);

    // R3: masks
    cur_req = "R3";
    program_ch(0, mk(4'b0001, 0, 6'h25, 6'h12, 7'h15, 7'h00));
    alm_en[0] = 1;
    set_cal(7'h47, 7'h15, 6'h12, 6'h25, 3);
    sec_tick = 1; tick();
    check("R3", "seconds masked", int'(flag_o[0]), 1);
    clear_ch(0);
    program_ch(0, mk(4'b1111, 0, 6'h01, 6'h01, 7'h01, 7'h01));
    alm_en[0] = 1;
    for (int i = 0; i < 3; i++) begin
      set_cal(7'(i), 7'h59, 6'h23, 6'h31, 7);
      sec_tick = 1; tick();
      check("R3", "all masked fires every tick", int'(flag_o[0]), 1);
      clear_ch(0);
      check("R3", "cleared between ticks", int'(flag_o[0]), 0);
    end

    // R4: weekday vs day of month
    cur_req = "R4";
    program_ch(0, mk(4'b0111, 1, 6'h07, 6'h00, 7'h00, 7'h00));
    alm_en[0] = 1;
    set_cal(0, 0, 0, 6'h07, 1);
    sec_tick = 1; tick();
    check("R4", "weekday mode ignores mday", int'(flag_o[0]), 0);
    set_cal(0, 0, 0, 6'h02, 7);
    sec_tick = 1; tick();
    check("R4", "sunday coded 7 matches", int'(flag_o[0]), 1);
    clear_ch(0);
    program_ch(0, mk(4'b0111, 0, 6'h07, 6'h00, 7'h00, 7'h00));
    alm_en[0] = 1;
    set_cal(0, 0, 0, 6'h02, 7);
    sec_tick = 1; tick();
    check("R4", "mday mode ignores weekday", int'(flag_o[0]), 0);
    set_cal(0, 0, 0, 6'h07, 2);
    sec_tick = 1; tick();
    check("R4", "mday mode match", int'(flag_o[0]), 1);
    clear_ch(0);

    // R5: no tick or disabled gives no flag
    cur_req = "R5";
    repeat (4) tick();
    check("R5", "no tick no flag", int'(flag_o[0]), 0);
    alm_en[0] = 0; sec_tick = 1; tick();
    check("R5", "disabled no flag", int'(flag_o[0]), 0);

    // R6: sticky, and set wins over clear
    cur_req = "R6";
    alm_en[0] = 1; sec_tick = 1; tick();
    repeat (5) tick();
    check("R6", "flag holds", int'(flag_o[0]), 1);
    sec_tick = 1; flag_clr[0] = 1; tick();
    check("R6", "set beats clear", int'(flag_o[0]), 1);
    clear_ch(0);
    check("R6", "clear drops flag", int'(flag_o[0]), 0);

    // R7: write-allowed timing; R8: write ignored while not allowed
    cur_req = "R7";
    alm_en[1] = 0; repeat (LAT + 1) tick();
    alm_en[1] = 1; wr_stb[1] = 1;
    wr_data = mk(4'b0000, 0, 6'h09, 6'h08, 7'h07, 7'h06); tick();
    check("R7", "wr_ok falls with enable", int'(wr_ok[1]), 0);
    cur_req = "R8";
    wr_stb[1] = 1; wr_data = mk(4'b1111, 0, 0, 0, 0, 0); tick();
    set_cal(7'h10, 7'h10, 6'h10, 6'h10, 1);
    sec_tick = 1; tick();
    check("R8", "ignored write left old setting", int'(flag_o[1]), 0);
    set_cal(7'h06, 7'h07, 6'h08, 6'h09, 1);
    sec_tick = 1; tick();
    check("R8", "landed write in enable cycle", int'(flag_o[1]), 1);

    // R9: independence
    cur_req = "R9";
    check("R9", "ch0 untouched by ch1 match", int'(flag_o[0]), 1'b0 ^ flag_o[0] ? 0 : 0);
    clear_ch(0);
    check("R9", "ch1 kept after ch0 clear", int'(flag_o[1]), 1);
    clear_ch(1);

    // R10: interrupt combination
    cur_req = "R10";
    irq_en = 2'b10; sec_tick = 1; tick();
    check("R10", "irq with ch1 enabled", int'(irq_o), 1);
    irq_en = 2'b01; tick();
    check("R10", "irq off when only ch0 enabled", int'(irq_o), 0);
    irq_en = 2'b00; clear_ch(1);
    repeat (2) tick();

    $display("test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule